// File: doc/BRIEF.md
# SD Command-Line Frame Engine

This block is the host-side engine for the single command wire of an SD-style card bus. When a request is accepted, the engine sends one 48-bit command frame. The frame carries a start bit, a host transmitter bit, the command index, the argument, a serially generated CRC7 and an end bit. The engine then holds the wire high for one more clock and releases it, so that the pull-up keeps the wire high during the turnaround.

After the release, the engine watches the sampled wire for the card's start bit. It stores the whole response frame, which is 48 or 136 bits long. It then reports the frame together with four error flags: response timing, framing, CRC and timeout.

Two timing disciplines are available for each command:
- Exact mode: used for identification and operating-condition commands. The response must start in precisely one clock slot.
- Minimum mode: used for address-assignment style commands. The response may start no earlier than a given slot.

Clock slots are numbered from the clock after the end bit, which is slot 1 (the actively driven high bit).

Top module: `sd_cmd_engine`

## Requirements
- R1: An accepted command is sent on `cmd_o` with `cmd_oe` high, most significant bit first. The 48 bits are: a start bit 0, a transmitter bit 1, the 6-bit index, the 32-bit argument, a CRC7 and an end bit 1. The CRC7 uses x^7+x^3+1, starts from zero, covers the first 40 bits and is sent MSB first. The first bit appears in the clock after acceptance.
- R2: In the clock after the end bit, `cmd_o` is 1 with `cmd_oe` still high (slot 1). From the next clock, `cmd_oe` is low until the next command.
- R3: `req_ready` is high only when the engine is idle. A request is taken when `req_valid` and `req_ready` are both high. Request inputs presented while busy do not change the frame being sent.
- R4: In exact mode (`req_exact`=1), a response start bit (first 0 sampled from slot 2 on) in any slot other than `NID` sets `err_timing`.
- R5: In minimum mode (`req_exact`=0), a start bit in a slot before `NCR_MIN` sets `err_timing`. Later slots are accepted.
- R6: The response is `RSP_W` (136) bits long when `req_long`=1 and 48 bits otherwise. `rsp_data` holds the whole frame, start bit included, right-aligned, with the first received bit at the highest occupied position and zeros above it.
- R7: `err_crc` is set when the received CRC (`rsp_data[7:1]`) differs from the CRC7 of bits 47..8 (short response) or bits 127..8 (long response). The bit ranges refer to `rsp_data` positions.
- R8: `err_frame` is set when the received transmitter bit (second bit of the frame) is not 0 or the last bit is not 1.
- R9: If no start bit is seen by the end of slot `TIMEOUT`, `rsp_valid` pulses with `err_timeout` set and all other flags clear, and the engine goes idle. A start bit in slot `TIMEOUT` itself is still received. The wire is ignored while the engine is idle.
- R10: After reset, `req_ready`=1, `cmd_oe`=0, `rsp_valid`=0 and all error flags are 0.
- R11: `rsp_valid` is a one-clock pulse, issued once per command. The flags and `rsp_data` hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Engine idle, request may be taken |
| req_index | input | IDX_W | Command index |
| req_arg | input | ARG_W | Command argument |
| req_exact | input | 1 | 1: exact response slot, 0: minimum slot |
| req_long | input | 1 | 1: long response, 0: 48-bit response |
| cmd_o | output | 1 | Value driven onto the command wire |
| cmd_oe | output | 1 | Output enable for the command wire |
| cmd_i | input | 1 | Sampled command wire |
| rsp_valid | output | 1 | Response or timeout result pulse |
| rsp_data | output | RSP_W | Received frame, right-aligned |
| err_timing | output | 1 | Start bit in a disallowed slot |
| err_frame | output | 1 | Bad transmitter or end bit |
| err_crc | output | 1 | CRC mismatch |
| err_timeout | output | 1 | No start bit within the window |

## Verification
In the last slot of the window, start-bit detection and the timeout decision fall on the same clock edge. The bench makes the card begin its start bit exactly in slot `TIMEOUT` and expects a normal, error-free response. In a second run, the card begins one slot later and the bench expects a timeout only, with the late frame ignored while the engine sits idle. Separately, a late start bit is combined with a corrupted CRC, and both flags must appear in the same result pulse.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int        CRC_W    = 7;
  localparam logic [6:0] CRC_POLY = 7'h09;  // x^7 + x^3 + 1

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_PBIT, TX_REL} tx_state_t;
  typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_RECV, RX_CHECK} rx_state_t;

  // one serial step of the CRC7 register
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic d);
    logic fb;
    fb = d ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? CRC_POLY : 7'h00);
  endfunction

endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             cmd_o,
  output logic             cmd_oe,
  output logic             idle,
  output logic             p_go
);

  localparam int BODY_W  = 2 + IDX_W + ARG_W;    // bits covered by the CRC
  localparam int FRAME_W = BODY_W + CRC_W + 1;
  localparam int POS_W   = $clog2(FRAME_W + 1);
  localparam logic [POS_W-1:0] BODY_END = POS_W'(BODY_W);
  localparam logic [POS_W-1:0] CRC_END  = POS_W'(FRAME_W - 1);

  tx_state_t           state;
  logic [BODY_W-2:0]   sh;       // transmitter bit, index, argument
  logic [CRC_W-1:0]    crc;
  logic [POS_W-1:0]    pos;

  assign idle = (state == TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TX_IDLE;
      sh     <= '0;
      crc    <= '0;
      pos    <= '0;
      cmd_o  <= 1'b1;
      cmd_oe <= 1'b0;
      p_go   <= 1'b0;
    end else begin
      p_go <= 1'b0;
      case (state)
        TX_IDLE: begin
          if (launch) begin
            cmd_o  <= 1'b0;                 // start bit
            cmd_oe <= 1'b1;
            crc    <= crc7_step(7'd0, 1'b0);
            sh     <= {1'b1, idx, arg};
            pos    <= POS_W'(1);
            state  <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (pos < BODY_END) begin
            cmd_o <= sh[BODY_W-2];
            crc   <= crc7_step(crc, sh[BODY_W-2]);
            sh    <= {sh[BODY_W-3:0], 1'b0};
          end else if (pos < CRC_END) begin
            cmd_o <= crc[CRC_W-1];
            crc   <= {crc[CRC_W-2:0], 1'b0};
          end else begin
            cmd_o <= 1'b1;                  // end bit
            state <= TX_PBIT;
          end
          pos <= pos + POS_W'(1);
        end
        TX_PBIT: begin
          cmd_o  <= 1'b1;                   // actively driven high slot
          cmd_oe <= 1'b1;
          p_go   <= 1'b1;
          state  <= TX_REL;
        end
        default: begin                      // TX_REL: hand the wire to the pull-up
          cmd_oe <= 1'b0;
          state  <= TX_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_cmd_pkg::*;
#(
  parameter int RSP_W   = 136,
  parameter int SHORT_W = 48,
  parameter int NID     = 5,
  parameter int NCR_MIN = 2,
  parameter int TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             exact,
  input  logic             long_rsp,
  input  logic             clear,
  input  logic             cmd_i,
  output logic             idle,
  output logic             rsp_valid,
  output logic [RSP_W-1:0] rsp_data,
  output logic             err_timing,
  output logic             err_frame,
  output logic             err_crc,
  output logic             err_timeout
);

  localparam int DCNT_W = $clog2(TIMEOUT + 1);
  localparam int RPOS_W = $clog2(RSP_W + 1);
  localparam logic [DCNT_W-1:0] SLOT_NID = DCNT_W'(NID);
  localparam logic [DCNT_W-1:0] SLOT_NCR = DCNT_W'(NCR_MIN);
  localparam logic [DCNT_W-1:0] SLOT_TMO = DCNT_W'(TIMEOUT);
  localparam logic [RPOS_W-1:0] LAST_L   = RPOS_W'(RSP_W - 1);
  localparam logic [RPOS_W-1:0] LAST_S   = RPOS_W'(SHORT_W - 1);
  localparam logic [RPOS_W-1:0] CRC_LO_L = RPOS_W'(8);
  localparam logic [RPOS_W-1:0] CRC_HI_L = RPOS_W'(RSP_W - 8);
  localparam logic [RPOS_W-1:0] CRC_HI_S = RPOS_W'(SHORT_W - 8);

  rx_state_t          state;
  logic [DCNT_W-1:0]  dcnt;
  logic [RPOS_W-1:0]  rpos;
  logic [RSP_W-1:0]   rsh;
  logic [CRC_W-1:0]   crc;
  logic               tim_bad;
  logic               covered;
  logic               t_bit;
  logic [RPOS_W-1:0]  last_pos;

  assign idle = (state == RX_IDLE);

  always_comb begin
    last_pos = long_rsp ? LAST_L : LAST_S;
    covered  = long_rsp ? ((rpos >= CRC_LO_L) && (rpos < CRC_HI_L)) : (rpos < CRC_HI_S);
    t_bit    = long_rsp ? rsh[RSP_W-2] : rsh[SHORT_W-2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= RX_IDLE;
      dcnt        <= '0;
      rpos        <= '0;
      rsh         <= '0;
      crc         <= '0;
      tim_bad     <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      err_timing  <= 1'b0;
      err_frame   <= 1'b0;
      err_crc     <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (clear) begin
        err_timing  <= 1'b0;
        err_frame   <= 1'b0;
        err_crc     <= 1'b0;
        err_timeout <= 1'b0;
      end
      case (state)
        RX_IDLE: begin
          if (arm) begin                    // slot 1 is driven by the host
            dcnt  <= DCNT_W'(2);
            state <= RX_WAIT;
          end
        end
        RX_WAIT: begin
          if (!cmd_i) begin
            tim_bad <= exact ? (dcnt != SLOT_NID) : (dcnt < SLOT_NCR);
            rsh     <= '0;
            crc     <= '0;
            rpos    <= RPOS_W'(1);
            state   <= RX_RECV;
          end else if (dcnt == SLOT_TMO) begin
            rsp_valid   <= 1'b1;
            err_timeout <= 1'b1;
            state       <= RX_IDLE;
          end else begin
            dcnt <= dcnt + DCNT_W'(1);
          end
        end
        RX_RECV: begin
          rsh <= {rsh[RSP_W-2:0], cmd_i};
          if (covered) crc <= crc7_step(crc, cmd_i);
          if (rpos == last_pos) state <= RX_CHECK;
          rpos <= rpos + RPOS_W'(1);
        end
        default: begin                      // RX_CHECK
          rsp_valid  <= 1'b1;
          rsp_data   <= rsh;
          err_timing <= tim_bad;
          err_frame  <= t_bit | ~rsh[0];
          err_crc    <= (rsh[7:1] != crc);
          state      <= RX_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int IDX_W   = 6,
  parameter int ARG_W   = 32,
  parameter int RSP_W   = 136,
  parameter int NID     = 5,
  parameter int NCR_MIN = 2,
  parameter int TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_index,
  input  logic [ARG_W-1:0] req_arg,
  input  logic             req_exact,
  input  logic             req_long,
  output logic             cmd_o,
  output logic             cmd_oe,
  input  logic             cmd_i,
  output logic             rsp_valid,
  output logic [RSP_W-1:0] rsp_data,
  output logic             err_timing,
  output logic             err_frame,
  output logic             err_crc,
  output logic             err_timeout
);

  localparam int SHORT_W = 2 + IDX_W + ARG_W + 8;

  logic tx_idle, rx_idle, p_go, launch;
  logic exact_q, long_q;

  assign req_ready = tx_idle & rx_idle;
  assign launch    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      exact_q <= 1'b0;
      long_q  <= 1'b0;
    end else if (launch) begin
      exact_q <= req_exact;
      long_q  <= req_long;
    end
  end

  sd_cmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .idx    (req_index),
    .arg    (req_arg),
    .cmd_o  (cmd_o),
    .cmd_oe (cmd_oe),
    .idle   (tx_idle),
    .p_go   (p_go)
  );

  sd_cmd_rx #(
    .RSP_W(RSP_W), .SHORT_W(SHORT_W), .NID(NID), .NCR_MIN(NCR_MIN), .TIMEOUT(TIMEOUT)
  ) u_rx (
    .clk         (clk),
    .rst         (rst),
    .arm         (p_go),
    .exact       (exact_q),
    .long_rsp    (long_q),
    .clear       (launch),
    .cmd_i       (cmd_i),
    .idle        (rx_idle),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .err_timing  (err_timing),
    .err_frame   (err_frame),
    .err_crc     (err_crc),
    .err_timeout (err_timeout)
  );

endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic cmd_o,
  input logic cmd_oe,
  input logic rsp_valid,
  input logic err_timing,
  input logic err_frame,
  input logic err_crc,
  input logic err_timeout
);

  // R1: a frame opens with a start bit of 0
  a_r1_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_oe) |-> !cmd_o);

  // R2: the wire is released only after a driven high slot
  a_r2_p_before_release: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_oe) |-> $past(cmd_o));

  // R2: no driving while a result is reported
  a_r2_quiet_on_result: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !cmd_oe);

  // R3: never ready while the host drives the wire
  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> !req_ready);

  // R3: an accepted request starts the frame on the next clock
  a_r3_accept_starts: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd_oe && !cmd_o));

  // R9: a timeout carries no other error
  a_r9_timeout_alone: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && err_timeout) |-> (!err_crc && !err_frame && !err_timing));

  // R10: reset state
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!cmd_oe && !rsp_valid && req_ready));

  // R11: single-cycle result pulse
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

bind sd_cmd_engine sd_cmd_engine_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .cmd_o       (cmd_o),
  .cmd_oe      (cmd_oe),
  .rsp_valid   (rsp_valid),
  .err_timing  (err_timing),
  .err_frame   (err_frame),
  .err_crc     (err_crc),
  .err_timeout (err_timeout)
);

// File: tb/test_sd_cmd_engine.sv
`timescale 1ns/1ps
module test_sd_cmd_engine;

  localparam int NID = 5;
  localparam int NCR = 4;
  localparam int TMO = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [5:0]   req_index = '0;
  logic [31:0]  req_arg = '0;
  logic         req_exact = 1'b0;
  logic         req_long = 1'b0;
  logic         cmd_o, cmd_oe;
  logic         card_oe = 1'b0;
  logic         card_val = 1'b1;
  logic         cmd_line;
  logic         rsp_valid;
  logic [135:0] rsp_data;
  logic         err_timing, err_frame, err_crc, err_timeout;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [135:0] d;
    logic tim, frm, crc, to;
  } exp_t;
  exp_t q[$];
  exp_t last_e;

  logic [48:0] tx_cap;
  int          tx_cnt = 0;

  always #2.5 clk = ~clk;

  // wire model: host wins, then card, then pull-up
  assign cmd_line = cmd_oe ? cmd_o : (card_oe ? card_val : 1'b1);

  sd_cmd_engine #(.NID(NID), .NCR_MIN(NCR), .TIMEOUT(TMO)) i_sd_cmd_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_arg(req_arg), .req_exact(req_exact), .req_long(req_long),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_line), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .err_timing(err_timing), .err_frame(err_frame),
    .err_crc(err_crc), .err_timeout(err_timeout)
  );

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [135:0] v, input int hi);
    logic [6:0] c = '0;
    for (int i = hi; i >= 8; i--) begin
      logic fb;
      fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  // host capture of every driven bit
  always @(negedge clk) begin
    if (cmd_oe) begin
      tx_cap = {tx_cap[47:0], cmd_o};
      tx_cnt = tx_cnt + 1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11 unexpected result", 136'(rsp_valid), 136'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        last_e = e;
        chk(err_timeout == e.to, "R9 timeout flag", 136'(err_timeout), 136'(e.to));
        chk(err_timing == e.tim, "R4 R5 timing flag", 136'(err_timing), 136'(e.tim));
        chk(err_frame == e.frm, "R8 frame flag", 136'(err_frame), 136'(e.frm));
        chk(err_crc == e.crc, "R7 crc flag", 136'(err_crc), 136'(e.crc));
        if (!e.to) chk(rsp_data == e.d, "R6 response data", rsp_data, e.d);
      end
    end
  end

  // corrupt: 0 none, 1 transmitter bit, 2 end bit, 3 crc bit
  task automatic run(input logic lng, input logic exact, input logic [5:0] idx,
                     input logic [31:0] arg, input int dly, input int corrupt);
    logic [47:0]  hf;
    logic [135:0] f;
    logic [135:0] h;
    int           len;
    exp_t         e;
    h = '0;
    h[47:0] = {1'b0, 1'b1, idx, arg, 7'd0, 1'b1};
    h[7:1] = crc7(h, 47);
    hf = h[47:0];
    f = '0;
    if (!lng) begin
      len = 48;
      f[47:0] = {1'b0, 1'b0, idx, arg, 7'd0, 1'b1};
      f[7:1] = crc7(f, 47);
    end else begin
      len = 136;
      f = {1'b0, 1'b0, 6'h3F, arg, ~arg, {arg[15:0], arg[31:16]}, arg[23:0], 7'd0, 1'b1};
      f[7:1] = crc7(f, 127);
    end
    if (corrupt == 1) f[len-2] = ~f[len-2];
    if (corrupt == 2) f[0] = ~f[0];
    if (corrupt == 3) f[1] = ~f[1];
    e.d   = f;
    e.to  = (dly == 0) || (dly > TMO);
    e.tim = !e.to && (exact ? (dly != NID) : (dly < NCR));
    e.frm = !e.to && (corrupt == 1 || corrupt == 2);
    e.crc = !e.to && (corrupt == 3);
    q.push_back(e);

    @(negedge clk);
    tx_cnt = 0;
    req_index = idx; req_arg = arg; req_exact = exact; req_long = lng;
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    // R3: busy-time inputs must not disturb the frame
    req_index = ~idx; req_arg = ~arg; req_exact = ~exact; req_long = ~lng;
    @(negedge cmd_oe);
    req_valid = 1'b0;
    chk(tx_cnt == 49 && tx_cap == {hf, 1'b1}, "R1 R2 R3 host frame",
        136'(tx_cap), 136'({hf, 1'b1}));
    if (dly != 0) begin
      repeat (dly - 2) @(posedge clk);
      #1;
      card_oe = 1'b1;
      for (int i = len - 1; i >= 0; i--) begin
        card_val = f[i];
        @(posedge clk);
        #1;
      end
      card_oe = 1'b0;
      card_val = 1'b1;
    end
    do @(negedge clk); while (!req_ready);
    @(negedge clk);
    chk(!rsp_valid, "R11 pulse ends", 136'(rsp_valid), 136'd0);
    chk({err_timing, err_frame, err_crc, err_timeout} ==
        {last_e.tim, last_e.frm, last_e.crc, last_e.to}, "R11 flags held",
        136'({err_timing, err_frame, err_crc, err_timeout}),
        136'({last_e.tim, last_e.frm, last_e.crc, last_e.to}));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", 136'(req_ready), 136'd1);
    chk(cmd_oe == 1'b0 && rsp_valid == 1'b0, "R10 idle outputs",
        136'({cmd_oe, rsp_valid}), 136'd0);
    chk({err_timing, err_frame, err_crc, err_timeout} == 4'd0, "R10 flags clear",
        136'({err_timing, err_frame, err_crc, err_timeout}), 136'd0);

    run(1'b0, 1'b1, 6'd2,  32'h0000_0000, NID,     0);  // R4 exact slot
    run(1'b0, 1'b1, 6'd1,  32'h40FF_8000, NID + 1, 0);  // R4 late
    run(1'b0, 1'b1, 6'd2,  32'h1234_5678, NID - 1, 0);  // R4 early
    run(1'b0, 1'b0, 6'd3,  32'hDEAD_BEEF, NCR,     0);  // R5 minimum
    run(1'b0, 1'b0, 6'd3,  32'h0001_0000, NCR - 1, 0);  // R5 early
    run(1'b0, 1'b0, 6'd55, 32'hCAFE_F00D, 17,      0);  // R5 late ok
    run(1'b1, 1'b0, 6'd9,  32'h8765_4321, 6,       0);  // R6 long
    run(1'b1, 1'b0, 6'd10, 32'h0F0F_00FF, NCR,     3);  // R7 long crc
    run(1'b1, 1'b1, 6'd2,  32'hAAAA_5555, NID,     1);  // R8 transmitter bit
    run(1'b0, 1'b0, 6'd7,  32'h3333_CCCC, 8,       2);  // R8 end bit
    run(1'b0, 1'b0, 6'd41, 32'h0BAD_CAFE, 9,       3);  // R7 short crc
    run(1'b0, 1'b1, 6'd1,  32'h00FF_8000, 0,       0);  // R9 silent card
    run(1'b0, 1'b0, 6'd13, 32'h5A5A_A5A5, TMO,     0);  // R9 last slot accepted
    run(1'b0, 1'b0, 6'd13, 32'h5A5A_A5A6, TMO + 1, 0);  // R9 too late, ignored
    run(1'b0, 1'b1, 6'd8,  32'h0000_01AA, NID + 2, 3);  // R4 and R7 together
    run(1'b0, 1'b1, 6'h3F, 32'hFFFF_FFFF, NID,     0);  // R1 all ones

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R11 every command answered", 136'(q.size()), 136'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule